// File: doc/BRIEF.md
# Shared RAM Time-Slot Arbiter

This block lets a CPU port and a display fetch port share one RAM whose data path is only 4 bits wide. Each byte moves as two nibble accesses, low nibble first, and both accesses finish inside one slot of two clocks. Slots alternate between even and odd. An even slot and the odd slot after it form one period. The CPU may use only the even slot of each period. This limit holds even when the RAM would otherwise sit idle.

In the low-bandwidth display class, the display port takes the odd slot of every period while the active-line flag is set. The CPU keeps its even slot. In the high-bandwidth class, during active lines, the display takes every slot and any CPU request waits. Outside active lines the display makes no fetches at all.

A state machine walks through the states ST_IDLE, ST_CPU_LO, ST_CPU_HI, ST_DSP_LO and ST_DSP_HI. Its transitions are:
- ST_CPU_LO goes to ST_CPU_HI.
- ST_DSP_LO goes to ST_DSP_HI.
- At each slot boundary, ST_IDLE, ST_CPU_HI and ST_DSP_HI pick the next slot's owner. The choice is "display claim", which leads to ST_DSP_LO, or "CPU grant", which leads to ST_CPU_LO, or "no claim", which leads to ST_IDLE.
- ST_IDLE stays in ST_IDLE when it is not at a slot boundary.

The slot counter runs freely and starts at zero in the first clock after reset.

Top module: `shared_ram_arbiter`

## Requirements
- R1: A byte at byte address a is held as two nibbles. The low nibble (bits 3:0) is at RAM address {a,0} and the high nibble (bits 7:4) is at {a,1}. A read accesses {a,0} in the first clock of a slot and {a,1} in the second, and returns {high,low}.
- R2: Slots are two clocks long. Clock n after reset (n = 0 in the first clock) lies in slot n/2, and a slot is even when (n/2) mod 2 is 0. A CPU access only takes an even slot, so cpu_ready is high only in clocks where n mod 4 = 2.
- R3: With the active-line flag low, a CPU that keeps issuing requests gets at most one transfer per period. Back-to-back transfers therefore complete 4 clocks apart, even though the RAM is otherwise idle.
- R4: In the low-bandwidth class (mode_hi = 0) with active_line high, the display fetches in every odd slot, so disp_valid is high in clocks where n mod 4 = 0. The CPU still completes one transfer per period.
- R5: In the high-bandwidth class (mode_hi = 1) with active_line high, the display fetches in every slot, so disp_valid pulses every 2 clocks. In this state cpu_ready stays low and ram_we stays low.
- R6: A blocked CPU request stays pending with cpu_ready low. It is granted at the first even slot the display does not own. If active_line falls in a clock with n mod 4 = 0, cpu_ready rises 6 clocks later, and the display delivers exactly one more byte.
- R7: With active_line low, disp_valid never rises, whatever the value of mode_hi.
- R8: A CPU write drives the low nibble of cpu_wdata on ram_wdata in the first clock of the slot and the high nibble in the second clock. ram_we is high in both clocks.
- R9: disp_valid is a one-clock pulse in the clock after the high-nibble access. In that same clock, disp_data holds the assembled byte.
- R10: While reset is applied, cpu_ready, disp_valid and ram_en are all low.
- R11: A CPU transfer and a display fetch never complete in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one nibble access per clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | CPU transfer request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | DATA_W | CPU write byte |
| cpu_rdata | output | DATA_W | CPU read byte, valid with cpu_ready |
| cpu_ready | output | 1 | One-clock completion pulse |
| disp_addr | input | ADDR_W | Display byte address, held stable during fetches |
| disp_data | output | DATA_W | Fetched display byte |
| disp_valid | output | 1 | One-clock strobe for disp_data |
| mode_hi | input | 1 | 1 = high-bandwidth class, 0 = low-bandwidth class |
| active_line | input | 1 | Active scanline flag |
| ram_addr | output | ADDR_W+1 | Nibble address {byte address, half} |
| ram_en | output | 1 | RAM access this clock |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | DATA_W/2 | Nibble written |
| ram_rdata | input | DATA_W/2 | Nibble read, combinational from ram_addr |

## Verification
Slot owners are chosen at the edge that ends the second clock of a slot. A request or an active-line change therefore takes effect in the next slot if it arrives before that edge. A CPU result appears 6 clocks after a request placed in a clock with n mod 4 = 0, and a display byte appears 4 clocks after active_line rises in such a clock. The bench aligns every stimulus to n mod 4 = 0 on its own cycle counter, which it clears at reset exactly as the slot counter is cleared. It then compares the completion clocks against those fixed offsets and counts strobes over windows whose expected totals follow from the slot pattern. Outputs are sampled at the falling edge, and inputs change just after it.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CPU_LO = 3'd1,
        ST_CPU_HI = 3'd2,
        ST_DSP_LO = 3'd3,
        ST_DSP_HI = 3'd4
    } slot_state_e;

endpackage

// File: rtl/ram_slot_timer.sv
module ram_slot_timer #(
    parameter int CLKS_PER_SLOT = 2
) (
    input  logic clk,
    input  logic rst,
    output logic slot_end,
    output logic slot_par
);
    localparam int SUB_W = (CLKS_PER_SLOT > 1) ? $clog2(CLKS_PER_SLOT) : 1;

    logic [SUB_W-1:0] sub_q;
    logic             par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            par_q <= 1'b0;
        end else if (slot_end) begin
            sub_q <= '0;
            par_q <= ~par_q;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

    assign slot_end = (sub_q == SUB_W'(CLKS_PER_SLOT - 1));
    assign slot_par = par_q;

endmodule

// File: rtl/ram_slot_fsm.sv
module ram_slot_fsm
    import ram_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic slot_end,
    input  logic slot_par,
    input  logic cpu_req,
    input  logic mode_hi,
    input  logic active_line,
    output logic sel_cpu,
    output logic sel_dsp,
    output logic hi_half,
    output logic xfer_on
);
    slot_state_e state_q, state_d;
    logic        next_par;
    logic        dsp_claim;
    logic        cpu_grant;

    // Owner of the slot that begins after this edge
    always_comb begin
        next_par  = ~slot_par;
        dsp_claim = active_line & (mode_hi | next_par);
        cpu_grant = cpu_req & ~next_par & ~dsp_claim;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CPU_LO: state_d = ST_CPU_HI;
            ST_DSP_LO: state_d = ST_DSP_HI;
            ST_IDLE, ST_CPU_HI, ST_DSP_HI: begin
                if (!slot_end)
                    state_d = ST_IDLE;
                else if (dsp_claim)
                    state_d = ST_DSP_LO;
                else if (cpu_grant)
                    state_d = ST_CPU_LO;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        sel_cpu = 1'b0;
        sel_dsp = 1'b0;
        hi_half = 1'b0;
        xfer_on = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CPU_LO: begin sel_cpu = 1'b1; xfer_on = 1'b1; end
            ST_CPU_HI: begin sel_cpu = 1'b1; xfer_on = 1'b1; hi_half = 1'b1; end
            ST_DSP_LO: begin sel_dsp = 1'b1; xfer_on = 1'b1; end
            ST_DSP_HI: begin sel_dsp = 1'b1; xfer_on = 1'b1; hi_half = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/ram_nibble_xfer.sv
module ram_nibble_xfer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_cpu,
    input  logic              sel_dsp,
    input  logic              hi_half,
    input  logic              xfer_on,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [ADDR_W-1:0] disp_addr,
    input  logic [DATA_W/2-1:0] ram_rdata,
    output logic [ADDR_W:0]   ram_addr,
    output logic              ram_en,
    output logic              ram_we,
    output logic [DATA_W/2-1:0] ram_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] disp_data,
    output logic              disp_valid
);
    localparam int NIB_W = DATA_W / 2;

    logic [ADDR_W-1:0] src_addr;
    logic [NIB_W-1:0]  lo_q;
    logic              wr_now;

    always_comb begin
        src_addr  = sel_cpu ? cpu_addr : disp_addr;
        wr_now    = sel_cpu & cpu_we;
        ram_addr  = {src_addr, hi_half};
        ram_en    = xfer_on;
        ram_we    = wr_now;
        ram_wdata = '0;
        if (wr_now)
            ram_wdata = hi_half ? cpu_wdata[DATA_W-1:NIB_W] : cpu_wdata[NIB_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q       <= '0;
            cpu_rdata  <= '0;
            cpu_ready  <= 1'b0;
            disp_data  <= '0;
            disp_valid <= 1'b0;
        end else begin
            if (xfer_on && !hi_half)
                lo_q <= ram_rdata;
            cpu_ready  <= sel_cpu & hi_half;
            disp_valid <= sel_dsp & hi_half;
            if (sel_cpu && hi_half && !cpu_we)
                cpu_rdata <= {ram_rdata, lo_q};
            if (sel_dsp && hi_half)
                disp_data <= {ram_rdata, lo_q};
        end
    end

endmodule

// File: rtl/shared_ram_arbiter.sv
module shared_ram_arbiter #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic [ADDR_W-1:0] disp_addr,
    output logic [DATA_W-1:0] disp_data,
    output logic              disp_valid,
    input  logic              mode_hi,
    input  logic              active_line,
    output logic [ADDR_W:0]   ram_addr,
    output logic              ram_en,
    output logic              ram_we,
    output logic [DATA_W/2-1:0] ram_wdata,
    input  logic [DATA_W/2-1:0] ram_rdata
);
    localparam int CLKS_PER_SLOT = 2;

    logic slot_end;
    logic slot_par;
    logic sel_cpu;
    logic sel_dsp;
    logic hi_half;
    logic xfer_on;

    ram_slot_timer #(.CLKS_PER_SLOT(CLKS_PER_SLOT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .slot_end (slot_end),
        .slot_par (slot_par)
    );

    ram_slot_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .slot_end    (slot_end),
        .slot_par    (slot_par),
        .cpu_req     (cpu_req),
        .mode_hi     (mode_hi),
        .active_line (active_line),
        .sel_cpu     (sel_cpu),
        .sel_dsp     (sel_dsp),
        .hi_half     (hi_half),
        .xfer_on     (xfer_on)
    );

    ram_nibble_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .sel_cpu    (sel_cpu),
        .sel_dsp    (sel_dsp),
        .hi_half    (hi_half),
        .xfer_on    (xfer_on),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .disp_addr  (disp_addr),
        .ram_rdata  (ram_rdata),
        .ram_addr   (ram_addr),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_wdata  (ram_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_ready  (cpu_ready),
        .disp_data  (disp_data),
        .disp_valid (disp_valid)
    );

endmodule

// File: rtl/ram_arb_checker.sv
module ram_arb_checker #(
    parameter int ADDR_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            cpu_ready,
    input logic            disp_valid,
    input logic            ram_en,
    input logic            ram_we,
    input logic [ADDR_W:0] ram_addr,
    input logic            slot_end,
    input logic            slot_par
);
    // R10: outputs quiet while reset is applied
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!cpu_ready && !disp_valid && !ram_en));

    // R2: CPU completion only right after an even slot
    a_r2_cpu_even_slot: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> (slot_par && !slot_end));

    // R3: completion is a single-clock pulse
    a_r3_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R9: display strobe is a single-clock pulse at a slot start
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        disp_valid |=> !disp_valid);

    a_r9_valid_slot_start: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> !slot_end);

    // R1: low nibble access is followed by high nibble of the same byte
    a_r1_nibble_pair: assert property (@(posedge clk) disable iff (rst)
        (ram_en && !ram_addr[0]) |=>
            (ram_en && ram_addr[0] && ram_addr[ADDR_W:1] == $past(ram_addr[ADDR_W:1])));

    // R8: write enable held for both halves, only with an access
    a_r8_write_pair: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !ram_addr[0]) |=> (ram_we && ram_addr[0]));

    a_r8_we_needs_en: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ram_en);

    // R11: CPU and display never complete together
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(cpu_ready && disp_valid));

endmodule

bind shared_ram_arbiter ram_arb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_ready  (cpu_ready),
    .disp_valid (disp_valid),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .slot_end   (slot_end),
    .slot_par   (slot_par)
);

// File: tb/sim_shared_ram_arbiter.sv
module sim_shared_ram_arbiter;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int NBYTES = 1 << ADDR_W;

    typedef struct {
        logic [DATA_W-1:0] data;
        bit                rd;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_ready;
    logic [ADDR_W-1:0] disp_addr = '0;
    logic [DATA_W-1:0] disp_data;
    logic              disp_valid;
    logic              mode_hi = 1'b0;
    logic              active_line = 1'b0;
    logic [ADDR_W:0]   ram_addr;
    logic              ram_en;
    logic              ram_we;
    logic [NIB_W-1:0]  ram_wdata;
    logic [NIB_W-1:0]  ram_rdata;

    logic [NIB_W-1:0]  ram_mem [0:2*NBYTES-1];
    logic [DATA_W-1:0] exp_mem [0:NBYTES-1];
    item_t             exp_q[$];

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    n_valid = 0;
    int    n_ready = 0;
    int    we_cnt = 0;
    int    vmod = 4;
    string vreq = "R4";
    bit    prev_we_lo = 1'b0;
    bit    done = 1'b0;
    bit    wdone = 1'b0;
    int    rcw = 0;
    logic [DATA_W-1:0] cur_wbyte = '0;
    logic [ADDR_W-1:0] cur_waddr = '0;

    always #10 clk = ~clk;

    shared_ram_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .disp_addr(disp_addr), .disp_data(disp_data), .disp_valid(disp_valid),
        .mode_hi(mode_hi), .active_line(active_line),
        .ram_addr(ram_addr), .ram_en(ram_en), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Nibble RAM model: combinational read, clocked write
    assign ram_rdata = ram_mem[ram_addr];
    always @(posedge clk) if (ram_en && ram_we) ram_mem[ram_addr] <= ram_wdata;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic align0();
        while (cyc % 4 != 0) step(1);
    endtask

    task automatic cpu_op(input bit we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, output int rc);
        item_t it;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_req   = 1'b1;
        if (we) begin
            exp_mem[a] = d;
            cur_wbyte  = d;
            cur_waddr  = a;
        end
        it.rd   = !we;
        it.data = exp_mem[a];
        exp_q.push_back(it);
        forever begin
            step(1);
            if (cpu_ready) break;
        end
        rc      = cyc;
        cpu_req = 1'b0;
    endtask

    // Monitor: scoreboard pops, display compare, write-pin checks
    always @(negedge clk) begin
        if (!rst) begin
            if (cpu_ready) begin
                n_ready++;
                chk(cyc % 4 == 2, "R2", "cpu_ready phase", cyc % 4, 2);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected cpu_ready", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    if (it.rd)
                        chk(cpu_rdata == it.data, "R1", "cpu_rdata",
                            int'(cpu_rdata), int'(it.data));
                end
            end
            if (disp_valid) begin
                n_valid++;
                chk(disp_data == exp_mem[disp_addr], "R9", "disp_data",
                    int'(disp_data), int'(exp_mem[disp_addr]));
                chk(cyc % vmod == 0, vreq, "disp_valid phase", cyc % vmod, 0);
            end
            if (ram_we) begin
                we_cnt++;
                chk(ram_wdata == (ram_addr[0] ? cur_wbyte[DATA_W-1:NIB_W]
                                              : cur_wbyte[NIB_W-1:0]),
                    "R8", "ram_wdata", int'(ram_wdata), int'(cur_wbyte));
                chk(ram_addr[ADDR_W:1] == cur_waddr, "R8", "write address",
                    int'(ram_addr[ADDR_W:1]), int'(cur_waddr));
                if (ram_addr[0])
                    chk(prev_we_lo, "R8", "high nibble after low", 0, 1);
            end
            prev_we_lo = ram_we && !ram_addr[0];
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int rc[4];
        int t0, c0, v0, r0, w0, rr;

        for (int n = 0; n < 2 * NBYTES; n++) ram_mem[n] = NIB_W'((n * 7 + 3) % 16);
        for (int a = 0; a < NBYTES; a++)
            exp_mem[a] = {NIB_W'(((2 * a + 1) * 7 + 3) % 16), NIB_W'(((2 * a) * 7 + 3) % 16)};

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!cpu_ready, "R10", "cpu_ready in reset", int'(cpu_ready), 0);
        chk(!disp_valid, "R10", "disp_valid in reset", int'(disp_valid), 0);
        chk(!ram_en, "R10", "ram_en in reset", int'(ram_en), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;

        // R2/R3: back-to-back reads with the display idle
        align0();
        t0 = cyc;
        cpu_op(1'b0, 8'd5, '0, rc[0]);
        cpu_op(1'b0, 8'd6, '0, rc[1]);
        cpu_op(1'b0, 8'd7, '0, rc[2]);
        cpu_op(1'b0, 8'd250, '0, rc[3]);
        chk(rc[0] == t0 + 6, "R2", "first ready clock", rc[0], t0 + 6);
        for (int i = 1; i < 4; i++)
            chk(rc[i] - rc[i-1] == 4, "R3", "ready spacing idle", rc[i] - rc[i-1], 4);

        // R8: writes, then read back
        w0 = we_cnt;
        cpu_op(1'b1, 8'd3, 8'hA5, rr);
        cpu_op(1'b1, 8'd200, 8'h3C, rr);
        chk(we_cnt - w0 == 4, "R8", "write enable clocks", we_cnt - w0, 4);
        cpu_op(1'b0, 8'd3, '0, rr);
        cpu_op(1'b0, 8'd200, '0, rr);

        // R4: low-bandwidth class during active line
        align0();
        disp_addr = 8'd3;
        mode_hi = 1'b0;
        vmod = 4;
        vreq = "R4";
        active_line = 1'b1;
        t0 = cyc;
        v0 = n_valid;
        cpu_op(1'b0, 8'd10, '0, rc[0]);
        cpu_op(1'b0, 8'd11, '0, rc[1]);
        cpu_op(1'b0, 8'd12, '0, rc[2]);
        cpu_op(1'b0, 8'd13, '0, rc[3]);
        chk(rc[0] == t0 + 6, "R4", "CPU slot kept", rc[0], t0 + 6);
        for (int i = 1; i < 4; i++)
            chk(rc[i] - rc[i-1] == 4, "R4", "ready spacing", rc[i] - rc[i-1], 4);
        step(t0 + 24 - cyc);
        chk(n_valid - v0 == 6, "R4", "display bytes", n_valid - v0, 6);
        active_line = 1'b0;
        v0 = n_valid;
        step(12);
        chk(n_valid == v0, "R7", "no fetch after line", n_valid - v0, 0);

        // R5/R6: high-bandwidth class stalls the CPU
        align0();
        disp_addr = 8'd200;
        mode_hi = 1'b1;
        vmod = 2;
        vreq = "R5";
        active_line = 1'b1;
        t0 = cyc;
        v0 = n_valid;
        r0 = n_ready;
        w0 = we_cnt;
        wdone = 1'b0;
        fork
            begin
                cpu_op(1'b1, 8'd9, 8'h5A, rcw);
                wdone = 1'b1;
            end
        join_none
        step(24);
        chk(n_valid - v0 == 11, "R5", "display every slot", n_valid - v0, 11);
        chk(n_ready == r0, "R5", "CPU stalled", n_ready - r0, 0);
        chk(we_cnt == w0, "R5", "no RAM write", we_cnt - w0, 0);
        active_line = 1'b0;
        c0 = cyc;
        wait (wdone);
        chk(rcw == c0 + 6, "R6", "blocked grant clock", rcw, c0 + 6);
        chk(n_valid - v0 == 12, "R6", "one trailing fetch", n_valid - v0, 12);
        step(1);
        cpu_op(1'b0, 8'd9, '0, rr);

        // R7: high-bandwidth class outside active line
        v0 = n_valid;
        cpu_op(1'b0, 8'd200, '0, rr);
        chk(rr % 4 == 2, "R7", "CPU slot outside line", rr % 4, 2);
        step(16);
        chk(n_valid == v0, "R7", "no display fetch", n_valid - v0, 0);
        chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule